// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block is a small data cache placed between a processor that reads and writes 32-bit words and a main memory that transfers whole 128-bit lines. It holds four lines, organised as two sets of two ways. Each line carries a tag, a valid flag and a dirty flag. Each set carries one recency bit. A lookup compares the tags of both ways of the addressed set in parallel. Writes that hit change only the cached copy. A modified line goes back to memory as a whole line, and only when it is chosen as a victim.

The control state machine has four states. IDLE waits for a processor request and latches it. LOOKUP compares the tags. On a hit it completes the request and returns to IDLE. On a miss it goes to EVICT when the chosen victim is valid and dirty, and to REFILL otherwise. EVICT writes the victim line out and moves to REFILL on the memory acknowledge. REFILL reads the missing line, installs it clean on the acknowledge and returns to LOOKUP. The repeated lookup now hits, so read data, write merging, dirty marking and the recency update all take the hit path.

The processor holds `cpu_req` and the request fields steady until it sees `cpu_ready` high. `cpu_ready` is high for exactly one cycle. The memory side holds `mem_req`, `mem_we` and `mem_addr` until a one-cycle `mem_ack`. On a read, `mem_rline` is valid in the acknowledge cycle.

Top module: `sa_wb_cache`

## Requirements
- R1: After reset no line is valid or dirty, `cpu_ready` and `mem_req` are low, and the first access to any address misses.
- R2: Address fields are: byte offset A[3:0] with word select A[3:2], set select A[4], and tag A[11:5]. A[1:0] has no effect on the word accessed. Word k of a line occupies line bits [32k+31:32k].
- R3: A hit needs a valid way in the addressed set whose tag matches. `cpu_ready` rises in the cycle after the request is taken, and no memory transaction occurs.
- R4: A read miss issues exactly one memory read at the line-aligned address {A[11:4],4'h0}. The requested word from the fetched line is returned only after that read completes.
- R5: A write hit replaces the addressed word in the cached line and marks the line dirty. It issues no memory write.
- R6: A write miss allocates the line. It fetches the line, merges the written word and leaves the line dirty. Later reads return the merged word.
- R7: When the victim is valid and dirty, exactly one memory write of the whole victim line, at {victim tag, set, 4'h0}, carries the latest contents. This write completes before the fill read starts.
- R8: When the victim is clean or invalid, the miss issues no memory write.
- R9: A miss fills way 0 if it is invalid, otherwise way 1 if it is invalid, otherwise the least recently used way of the set. Hits and fills both make the recency bit point at the other way.
- R10: `cpu_ready` is low while a memory transaction is pending. `mem_req`, `mem_we` and `mem_addr` stay stable until `mem_ack`. `mem_we` is high only for write-backs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = word write, 0 = word read |
| cpu_addr | input | 12 | Byte address of the word |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, valid while `cpu_ready` is high |
| mem_req | output | 1 | Memory line transaction request |
| mem_we | output | 1 | 1 = line write-back, 0 = line fill |
| mem_addr | output | 12 | Line-aligned memory address |
| mem_wline | output | 128 | Victim line data for write-back |
| mem_ack | input | 1 | One-cycle memory completion |
| mem_rline | input | 128 | Fill data, valid with `mem_ack` |

## Verification
A request is taken at the first rising edge that sees it. On a hit, `cpu_ready` is visible in the following cycle, so the bench samples at each falling edge and expects completion on the first one for a predicted hit. A miss completes one cycle after the fill acknowledge, or after both acknowledges when the victim is dirty. For misses the bench waits for `cpu_ready` and then compares the number, direction, address and data of the recorded memory transactions with a bench model of tags, flags and recency. That model predicts the hit or miss, the victim and the expected write-back line before each access is issued.

// File: rtl/cache_pkg.sv
package cache_pkg;

    typedef enum logic [1:0] {
        CS_IDLE   = 2'd0,
        CS_LOOKUP = 2'd1,
        CS_EVICT  = 2'd2,
        CS_REFILL = 2'd3
    } cache_state_e;

    localparam int unsigned NWAYS = 2;

endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
    parameter int unsigned TAG_W = 7,
    parameter int unsigned SET_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] look_set,
    input  logic [TAG_W-1:0] look_tag,
    output logic             hit,
    output logic             hit_way,
    output logic             vict_way,
    output logic             vict_valid,
    output logic             vict_dirty,
    output logic [TAG_W-1:0] vict_tag,
    input  logic             touch_en,
    input  logic             mark_dirty,
    input  logic             fill_en
);
    import cache_pkg::*;

    localparam int unsigned NSETS = 1 << SET_W;

    logic [TAG_W-1:0] tag_q   [NSETS][NWAYS];
    logic             valid_q [NSETS][NWAYS];
    logic             dirty_q [NSETS][NWAYS];
    logic             lru_q   [NSETS];
    logic [NWAYS-1:0] hit_vec;

    for (genvar w = 0; w < NWAYS; w++) begin : g_cmp
        assign hit_vec[w] = valid_q[look_set][w] && (tag_q[look_set][w] == look_tag);
    end

    always_comb begin
        hit      = |hit_vec;
        hit_way  = hit_vec[1];
        if (!valid_q[look_set][0])      vict_way = 1'b0;
        else if (!valid_q[look_set][1]) vict_way = 1'b1;
        else                            vict_way = lru_q[look_set];
        vict_valid = valid_q[look_set][vict_way];
        vict_dirty = dirty_q[look_set][vict_way];
        vict_tag   = tag_q[look_set][vict_way];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NSETS; s++) begin
                lru_q[s] <= 1'b0;
                for (int w = 0; w < NWAYS; w++) begin
                    tag_q[s][w]   <= '0;
                    valid_q[s][w] <= 1'b0;
                    dirty_q[s][w] <= 1'b0;
                end
            end
        end else begin
            if (fill_en) begin
                tag_q[look_set][vict_way]   <= look_tag;
                valid_q[look_set][vict_way] <= 1'b1;
                dirty_q[look_set][vict_way] <= 1'b0;
                lru_q[look_set]             <= ~vict_way;
            end else if (touch_en) begin
                lru_q[look_set] <= ~hit_way;
                if (mark_dirty) dirty_q[look_set][hit_way] <= 1'b1;
            end
        end
    end

    a_r9_single_way_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    a_r9_fill_installs: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> hit);

    a_r5_dirty_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (touch_en && mark_dirty) |=> (hit && vict_valid) || !hit || dirty_q[$past(look_set)][$past(hit_way)]);

endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
    parameter int unsigned SET_W  = 1,
    parameter int unsigned WORD_W = 32,
    parameter int unsigned WORDS  = 4
) (
    input  logic                      clk,
    input  logic [SET_W-1:0]          set_idx,
    input  logic                      hit_way,
    input  logic                      vict_way,
    input  logic [$clog2(WORDS)-1:0]  word_sel,
    output logic [WORD_W-1:0]         rd_word,
    output logic [WORD_W*WORDS-1:0]   vict_line,
    input  logic                      wr_word_en,
    input  logic [WORD_W-1:0]         wr_word,
    input  logic                      fill_en,
    input  logic [WORD_W*WORDS-1:0]   fill_line
);
    import cache_pkg::*;

    localparam int unsigned NSETS  = 1 << SET_W;
    localparam int unsigned LINE_W = WORD_W * WORDS;

    logic [LINE_W-1:0] line_q [NSETS][NWAYS];

    assign rd_word   = line_q[set_idx][hit_way][word_sel*WORD_W +: WORD_W];
    assign vict_line = line_q[set_idx][vict_way];

    always_ff @(posedge clk) begin
        if (fill_en)
            line_q[set_idx][vict_way] <= fill_line;
        else if (wr_word_en)
            line_q[set_idx][hit_way][word_sel*WORD_W +: WORD_W] <= wr_word;
    end

endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned SET_W  = 1,
    parameter int unsigned WORD_W = 32,
    parameter int unsigned WORDS  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cpu_req,
    input  logic                      cpu_we,
    input  logic [ADDR_W-1:0]         cpu_addr,
    input  logic [WORD_W-1:0]         cpu_wdata,
    output logic                      cpu_ready,
    output logic                      mem_req,
    output logic                      mem_we,
    output logic [ADDR_W-1:0]         mem_addr,
    input  logic                      mem_ack,
    output logic [SET_W-1:0]          look_set,
    output logic [ADDR_W-SET_W-$clog2(WORDS)-$clog2(WORD_W/8)-1:0] look_tag,
    output logic [$clog2(WORDS)-1:0]  word_sel,
    output logic [WORD_W-1:0]         wdata_q,
    input  logic                      hit,
    input  logic                      vict_valid,
    input  logic                      vict_dirty,
    input  logic [ADDR_W-SET_W-$clog2(WORDS)-$clog2(WORD_W/8)-1:0] vict_tag,
    output logic                      touch_en,
    output logic                      mark_dirty,
    output logic                      wr_word_en,
    output logic                      fill_en
);
    import cache_pkg::*;

    localparam int unsigned BSEL_W = $clog2(WORD_W / 8);
    localparam int unsigned WSEL_W = $clog2(WORDS);
    localparam int unsigned OFFS_W = BSEL_W + WSEL_W;
    localparam int unsigned TAG_W  = ADDR_W - SET_W - OFFS_W;

    cache_state_e state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic              we_q;

    assign look_tag = addr_q[ADDR_W-1 -: TAG_W];
    assign look_set = addr_q[OFFS_W +: SET_W];
    assign word_sel = addr_q[BSEL_W +: WSEL_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CS_IDLE;
            addr_q  <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == CS_IDLE && cpu_req) begin
                addr_q  <= cpu_addr;
                we_q    <= cpu_we;
                wdata_q <= cpu_wdata;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_IDLE:   if (cpu_req) state_d = CS_LOOKUP;
            CS_LOOKUP: begin
                if (hit)                          state_d = CS_IDLE;
                else if (vict_valid && vict_dirty) state_d = CS_EVICT;
                else                              state_d = CS_REFILL;
            end
            CS_EVICT:  if (mem_ack) state_d = CS_REFILL;
            CS_REFILL: if (mem_ack) state_d = CS_LOOKUP;
        endcase
    end

    always_comb begin
        cpu_ready  = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = {look_tag, look_set, {OFFS_W{1'b0}}};
        touch_en   = 1'b0;
        mark_dirty = 1'b0;
        wr_word_en = 1'b0;
        fill_en    = 1'b0;
        unique case (state_q)
            CS_IDLE: ;
            CS_LOOKUP: begin
                cpu_ready  = hit;
                touch_en   = hit;
                mark_dirty = hit && we_q;
                wr_word_en = hit && we_q;
            end
            CS_EVICT: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = {vict_tag, look_set, {OFFS_W{1'b0}}};
            end
            CS_REFILL: begin
                mem_req = 1'b1;
                fill_en = mem_ack;
            end
        endcase
    end

    a_r10_no_ready_with_mem: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cpu_ready);

    a_r10_mem_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req && $stable(mem_we) && $stable(mem_addr));

    a_r7_wb_only_dirty: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (vict_valid && vict_dirty));

    a_r7_wb_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

    a_r3_hit_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && touch_en) |=> !mem_req);

endmodule

// File: rtl/sa_wb_cache.sv
module sa_wb_cache #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned SET_W  = 1,
    parameter int unsigned WORD_W = 32,
    parameter int unsigned WORDS  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_req,
    input  logic                    cpu_we,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [WORD_W-1:0]       cpu_wdata,
    output logic                    cpu_ready,
    output logic [WORD_W-1:0]       cpu_rdata,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [WORD_W*WORDS-1:0] mem_wline,
    input  logic                    mem_ack,
    input  logic [WORD_W*WORDS-1:0] mem_rline
);
    localparam int unsigned WSEL_W = $clog2(WORDS);
    localparam int unsigned OFFS_W = WSEL_W + $clog2(WORD_W / 8);
    localparam int unsigned TAG_W  = ADDR_W - SET_W - OFFS_W;

    logic [SET_W-1:0]  look_set;
    logic [TAG_W-1:0]  look_tag, vict_tag;
    logic [WSEL_W-1:0] word_sel;
    logic [WORD_W-1:0] wdata_q;
    logic hit, hit_way, vict_way, vict_valid, vict_dirty;
    logic touch_en, mark_dirty, wr_word_en, fill_en;

    cache_ctrl #(.ADDR_W(ADDR_W), .SET_W(SET_W), .WORD_W(WORD_W), .WORDS(WORDS)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .look_set(look_set), .look_tag(look_tag), .word_sel(word_sel), .wdata_q(wdata_q),
        .hit(hit), .vict_valid(vict_valid), .vict_dirty(vict_dirty), .vict_tag(vict_tag),
        .touch_en(touch_en), .mark_dirty(mark_dirty), .wr_word_en(wr_word_en), .fill_en(fill_en)
    );

    cache_tag_store #(.TAG_W(TAG_W), .SET_W(SET_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .look_set(look_set), .look_tag(look_tag),
        .hit(hit), .hit_way(hit_way), .vict_way(vict_way),
        .vict_valid(vict_valid), .vict_dirty(vict_dirty), .vict_tag(vict_tag),
        .touch_en(touch_en), .mark_dirty(mark_dirty), .fill_en(fill_en)
    );

    cache_data_store #(.SET_W(SET_W), .WORD_W(WORD_W), .WORDS(WORDS)) u_data (
        .clk(clk), .set_idx(look_set), .hit_way(hit_way), .vict_way(vict_way),
        .word_sel(word_sel), .rd_word(cpu_rdata), .vict_line(mem_wline),
        .wr_word_en(wr_word_en), .wr_word(wdata_q),
        .fill_en(fill_en), .fill_line(mem_rline)
    );

endmodule

// File: tb/sa_wb_cache_tb.sv
module sa_wb_cache_tb;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_req = 1'b0, cpu_we = 1'b0;
    logic [11:0]  cpu_addr = '0;
    logic [31:0]  cpu_wdata = '0;
    logic         cpu_ready;
    logic [31:0]  cpu_rdata;
    logic         mem_req, mem_we;
    logic [11:0]  mem_addr;
    logic [127:0] mem_wline;
    logic         mem_ack = 1'b0;
    logic [127:0] mem_rline = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sa_wb_cache u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wline(mem_wline),
        .mem_ack(mem_ack), .mem_rline(mem_rline)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic [31:0]  gmem [1024];
    logic [127:0] bmem [256];
    logic [6:0]   mt [2][2];
    bit           mv [2][2];
    bit           md [2][2];
    bit           ml [2];

    int           n_rd, n_wr, lat_cnt, lat_tgt;
    logic [11:0]  rd_addr_seen, wb_addr_seen;
    logic [127:0] wb_line_seen;

    function automatic logic [31:0] pattern(int i);
        return (i * 32'h9E3779B1) ^ 32'h5A5A0000;
    endfunction

    function automatic logic [127:0] gline(logic [7:0] idx);
        logic [127:0] l;
        for (int k = 0; k < 4; k++) l[k*32 +: 32] = gmem[{idx, 2'(k)}];
        return l;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // memory model: one-cycle ack after a variable latency
    always begin
        @(negedge clk);
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req && rst_n) begin
            if (lat_cnt >= lat_tgt) begin
                mem_ack = 1'b1;
                lat_cnt = 0;
                lat_tgt = $urandom % 4;
                if (mem_we) begin
                    n_wr++;
                    wb_addr_seen = mem_addr;
                    wb_line_seen = mem_wline;
                    bmem[mem_addr[11:4]] = mem_wline;
                end else begin
                    n_rd++;
                    rd_addr_seen = mem_addr;
                    mem_rline = bmem[mem_addr[11:4]];
                end
            end else begin
                lat_cnt++;
            end
        end
    end

    task automatic access(bit we, logic [11:0] addr, logic [31:0] wd, string tag_req);
        bit s;
        logic [6:0] t;
        bit h0, h1, hit, w, exp_wb;
        logic [11:0] wb_addr;
        logic [127:0] wb_line;
        logic [31:0] exp_rd;
        int cyc;
        s  = addr[4];
        t  = addr[11:5];
        h0 = mv[s][0] && mt[s][0] == t;
        h1 = mv[s][1] && mt[s][1] == t;
        hit = h0 || h1;
        exp_wb = 0;
        wb_addr = '0;
        wb_line = '0;
        if (hit) w = h1;
        else begin
            w = !mv[s][0] ? 1'b0 : (!mv[s][1] ? 1'b1 : ml[s]);
            exp_wb = mv[s][w] && md[s][w];
            wb_addr = {mt[s][w], s, 4'h0};
            wb_line = gline(wb_addr[11:4]);
            mt[s][w] = t; mv[s][w] = 1; md[s][w] = 0;
        end
        ml[s] = ~w;
        exp_rd = gmem[addr[11:2]];
        if (we) begin md[s][w] = 1; gmem[addr[11:2]] = wd; end

        n_rd = 0; n_wr = 0;
        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!cpu_ready && !done);
        if (!we) chk(cpu_rdata == exp_rd, hit ? "R3" : "R4", "read data", cpu_rdata, exp_rd);
        cpu_req = 0;
        if (hit) begin
            chk(cyc == 1, "R3", "hit latency", cyc, 1);
            chk(n_rd == 0 && n_wr == 0, we ? "R5" : "R3", "no memory traffic on hit", n_rd + n_wr, 0);
        end else begin
            chk(n_rd == 1, tag_req, "one fill read", n_rd, 1);
            chk(rd_addr_seen == {addr[11:4], 4'h0}, "R4", "fill address", rd_addr_seen, {addr[11:4], 4'h0});
            if (exp_wb) begin
                chk(n_wr == 1, "R7", "write-back count", n_wr, 1);
                chk(wb_addr_seen == wb_addr, "R7", "write-back address", wb_addr_seen, wb_addr);
                chk(wb_line_seen == wb_line, "R7", "write-back line", wb_line_seen, wb_line);
            end else begin
                chk(n_wr == 0, "R8", "no write-back for clean victim", n_wr, 0);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd2718));
        lat_cnt = 0; lat_tgt = 1;
        for (int i = 0; i < 1024; i++) gmem[i] = pattern(i);
        for (int i = 0; i < 256; i++) bmem[i] = gline(8'(i));
        for (int s = 0; s < 2; s++) begin
            ml[s] = 0;
            for (int w = 0; w < 2; w++) begin mv[s][w] = 0; md[s][w] = 0; mt[s][w] = '0; end
        end
        repeat (3) @(negedge clk);
        chk(cpu_ready == 0 && mem_req == 0, "R1", "outputs in reset", {cpu_ready, mem_req}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(cpu_ready == 0 && mem_req == 0, "R1", "idle after reset", {cpu_ready, mem_req}, 0);

        access(0, 12'h000, 0, "R1");            // cold miss, fills way 0 (R9)
        access(0, 12'h004, 0, "R3");            // hit
        access(0, 12'h007, 0, "R2");            // low bits ignored: same word as 0x004
        chk(cpu_rdata == gmem[1], "R2", "A[1:0] ignored", cpu_rdata, gmem[1]);
        access(1, 12'h008, 32'hCAFE0008, "R5"); // write hit, no memory write
        access(0, 12'h008, 0, "R5");
        access(0, 12'h040, 0, "R9");            // invalid way 1 filled
        access(0, 12'h000, 0, "R9");            // hit, recency points at way 1
        access(0, 12'h080, 0, "R8");            // evicts clean way 1
        access(0, 12'h040, 0, "R7");            // evicts dirty way 0 (0x000)
        access(1, 12'h0C4, 32'h0BADF00D, "R6"); // write miss allocates
        access(0, 12'h0C4, 0, "R6");
        access(0, 12'h014, 0, "R4");            // set 1 miss
        access(0, 12'h008, 0, "R7");            // refetch of written-back word

        for (int i = 0; i < 600; i++) begin
            logic [11:0] a;
            a = (($urandom % 8) == 0) ? 12'($urandom) : (12'($urandom) & 12'h0FF);
            access(1'($urandom), a, $urandom, "R4");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule